// File: doc/BRIEF.md
# Single-Operand Shift and Byte Unit

This unit is the datapath slice of a 16-bit processor's execute stage that handles the one-operand data instructions. These are the arithmetic shift right, the rotate right through carry, the byte swap and the sign extension. Each cycle it takes an operation code, a byte/word size request, the operand and the current status flags. One clock edge later it presents the result and the updated flags.

The shift and rotate honour the size request. In byte mode they act on the low byte only and return a zero upper byte. The byte swap and the sign extension always work on the full 16-bit word, whatever size was requested. Operand fetch, write-back, stack instructions and the left rotates are handled by other units.

Top module: `sop_unit`

## Requirements
- R1: While rst_ni is low, result_o and flags_o read zero. This holds asynchronously, without waiting for a clock edge.
- R2: Inputs present on one rising edge of clk_i appear on result_o and flags_o right after that edge. The outputs do not change before it.
- R3: op_i=2'b00 (arithmetic shift right, word mode) returns the operand shifted right by one with bit 15 kept.
- R4: op_i=2'b01 (rotate right through carry, word mode) returns the operand shifted right by one with the incoming carry flags_i[0] placed in bit 15.
- R5: With byte_i=1, op_i=2'b00 and 2'b01 act on bits 7:0, using bit 7 as the top bit, and result bits 15:8 are zero.
- R6: op_i=2'b10 exchanges bits 15:8 and 7:0, copies flags_i to flags_o unchanged, and ignores byte_i.
- R7: op_i=2'b11 copies bit 7 into bits 15:8 and ignores byte_i. C is set to NOT Z.
- R8: The flag vector is {V,N,Z,C} at bits 3..0. For op_i 2'b00, 2'b01 and 2'b11, V is cleared and N is the top bit of the active width. Z is set when the result is zero. For both right shifts, C takes the operand's old bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Operation: 00 shift, 01 rotate, 10 swap, 11 sign extend |
| byte_i | input | 1 | Byte-size request |
| operand_i | input | 16 | Operand |
| flags_i | input | 4 | Incoming flags {V,N,Z,C} |
| result_o | output | 16 | Registered result |
| flags_o | output | 4 | Registered flags {V,N,Z,C} |

## Verification
Every result and flag is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and samples on the next falling edge, so exactly one register stage lies between stimulus and check. A directed check samples just before the edge to confirm that the old value still holds. The reset checks sample a nanosecond after rst_ni falls, which shows that reset acts without a clock edge.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    SOP_RRA  = 2'b00,
    SOP_RRC  = 2'b01,
    SOP_SWPB = 2'b10,
    SOP_SXT  = 2'b11
  } sop_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } sop_flags_t;
endpackage

// File: rtl/sop_shift.sv
module sop_shift #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              byte_i,
  input  logic              rotate_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic              fill_word;
  logic              fill_byte;
  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] byte_res;

  always_comb begin
    fill_word = rotate_i ? carry_i : operand_i[DATA_W-1];
    fill_byte = rotate_i ? carry_i : operand_i[BYTE_W-1];
    word_res  = {fill_word, operand_i[DATA_W-1:1]};
    byte_res  = {{BYTE_W{1'b0}}, fill_byte, operand_i[BYTE_W-1:1]};
    result_o  = byte_i ? byte_res : word_res;
    carry_o   = operand_i[0];
  end
endmodule

// File: rtl/sop_byte.sv
module sop_byte #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] swap_o,
  output logic [DATA_W-1:0] sext_o
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  always_comb begin
    swap_o = {operand_i[BYTE_W-1:0], operand_i[DATA_W-1:BYTE_W]};
    sext_o = {{BYTE_W{operand_i[BYTE_W-1]}}, operand_i[BYTE_W-1:0]};
  end
endmodule

// File: rtl/sop_flags.sv
module sop_flags #(
  parameter int unsigned DATA_W = 16
) (
  input  sop_pkg::sop_op_e   op_i,
  input  logic               byte_i,
  input  logic [DATA_W-1:0]  result_i,
  input  logic               shift_c_i,
  input  sop_pkg::sop_flags_t flags_i,
  output sop_pkg::sop_flags_t flags_o
);
  import sop_pkg::*;
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic top_bit;
  logic is_zero;

  always_comb begin
    top_bit = byte_i ? result_i[BYTE_W-1] : result_i[DATA_W-1];
    is_zero = (result_i == '0);
    flags_o = flags_i;
    unique case (op_i)
      SOP_RRA, SOP_RRC: begin
        flags_o.v = 1'b0;
        flags_o.n = top_bit;
        flags_o.z = is_zero;
        flags_o.c = shift_c_i;
      end
      SOP_SXT: begin
        flags_o.v = 1'b0;
        flags_o.n = result_i[DATA_W-1];
        flags_o.z = is_zero;
        flags_o.c = ~is_zero;
      end
      default: flags_o = flags_i;
    endcase
  end
endmodule

// File: rtl/sop_unit.sv
module sop_unit #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o
);
  import sop_pkg::*;

  sop_op_e           op;
  sop_flags_t        flags_in;
  sop_flags_t        flags_nxt;
  logic              shift_byte;
  logic [DATA_W-1:0] shift_res;
  logic              shift_c;
  logic [DATA_W-1:0] swap_res;
  logic [DATA_W-1:0] sext_res;
  logic [DATA_W-1:0] result_nxt;
  logic [DATA_W-1:0] result_q;
  logic [3:0]        flags_q;

  assign op       = sop_op_e'(op_i);
  assign flags_in = sop_flags_t'(flags_i);
  // size request only honoured by the shifts
  assign shift_byte = byte_i & ((op == SOP_RRA) | (op == SOP_RRC));

  sop_shift #(.DATA_W(DATA_W)) i_shift (
    .operand_i (operand_i),
    .byte_i    (shift_byte),
    .rotate_i  (op == SOP_RRC),
    .carry_i   (flags_in.c),
    .result_o  (shift_res),
    .carry_o   (shift_c)
  );

  sop_byte #(.DATA_W(DATA_W)) i_byte (
    .operand_i (operand_i),
    .swap_o    (swap_res),
    .sext_o    (sext_res)
  );

  always_comb begin
    unique case (op)
      SOP_SWPB: result_nxt = swap_res;
      SOP_SXT:  result_nxt = sext_res;
      default:  result_nxt = shift_res;
    endcase
  end

  sop_flags #(.DATA_W(DATA_W)) i_flags (
    .op_i      (op),
    .byte_i    (shift_byte),
    .result_i  (result_nxt),
    .shift_c_i (shift_c),
    .flags_i   (flags_in),
    .flags_o   (flags_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      result_q <= result_nxt;
      flags_q  <= flags_nxt;
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;
endmodule

// File: rtl/sop_unit_chk.sv
module sop_unit_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        op_i,
  input logic              byte_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        flags_o
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  AST_SWPB_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10) |=> result_o == {$past(operand_i[BYTE_W-1:0]), $past(operand_i[DATA_W-1:BYTE_W])}); // R6
  AST_SWPB_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10) |=> flags_o == $past(flags_i)); // R6
  AST_SXT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11) |=> flags_o[0] == !flags_o[1]); // R7
  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_i && !op_i[1]) |=> result_o[DATA_W-1:BYTE_W] == '0); // R5
  AST_V_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 2'b10) |=> !flags_o[3]); // R8
  AST_SHIFT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i[1]) |=> flags_o[0] == $past(operand_i[0])); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 2'b10) |=> flags_o[1] == (result_o == '0)); // R8
endmodule

bind sop_unit sop_unit_chk #(.DATA_W(DATA_W)) i_sop_unit_chk (.*);

// File: tb/test_sop_unit.sv
`timescale 1ns/1ps
module test_sop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = '0;
  logic        byte_m = 1'b0;
  logic [15:0] operand = '0;
  logic [3:0]  flags_in = '0;
  logic [15:0] result;
  logic [3:0]  flags_out;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sop_unit i_sop_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .byte_i(byte_m),
    .operand_i(operand), .flags_i(flags_in),
    .result_o(result), .flags_o(flags_out)
  );

  // {op, byte, flags_in, operand, exp_result, exp_flags}; flags {V,N,Z,C}
  localparam int NV = 13;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 1'b0, 4'h0, 16'hF009, 16'hF804, 4'h5},
    {2'd1, 1'b0, 4'h1, 16'hF804, 16'hFC02, 4'h4},
    {2'd2, 1'b0, 4'hA, 16'hFC02, 16'h02FC, 4'hA},
    {2'd3, 1'b0, 4'h0, 16'h02FC, 16'hFFFC, 4'h5},
    {2'd3, 1'b1, 4'hF, 16'h1234, 16'h0034, 4'h1},
    {2'd3, 1'b0, 4'h0, 16'hFF00, 16'h0000, 4'h2},
    {2'd0, 1'b1, 4'h0, 16'hAB81, 16'h00C0, 4'h5},
    {2'd1, 1'b1, 4'h8, 16'h1201, 16'h0000, 4'h3},
    {2'd1, 1'b0, 4'h0, 16'h0001, 16'h0000, 4'h3},
    {2'd0, 1'b0, 4'h9, 16'h0000, 16'h0000, 4'h2},
    {2'd2, 1'b1, 4'h5, 16'h1234, 16'h3412, 4'h5},
    {2'd1, 1'b1, 4'h1, 16'h00FE, 16'h00FF, 4'h4},
    {2'd0, 1'b0, 4'h1, 16'h4002, 16'h2001, 4'h0}
  };
  string tags [NV] = '{"R3", "R4", "R6", "R7", "R7", "R7", "R5", "R5", "R8",
                       "R8", "R6", "R5", "R3"};

  task automatic check(string tag, logic [15:0] er, logic [3:0] ef);
    checks++;
    if (result !== er || flags_out !== ef) begin
      fails++;
      $display("FAIL %s result=%h flags=%h expected result=%h flags=%h",
               tag, result, flags_out, er, ef);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1 check("R1", 16'h0000, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {op, byte_m, flags_in, operand} = VEC[i][42:20];
      @(negedge clk);
      check(tags[i], VEC[i][19:4], VEC[i][3:0]);
    end
    // R2: new input applied, output must not move before the edge
    {op, byte_m, flags_in, operand} = {2'd2, 1'b0, 4'h7, 16'hABCD};
    #1 check("R2", 16'h2001, 4'h0);
    @(negedge clk); check("R2", 16'hCDAB, 4'h7);
    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 check("R1", 16'h0000, 4'h0);
    @(negedge clk); check("R1", 16'h0000, 4'h0);
    rst_n = 1'b1;
    @(negedge clk); check("R6", 16'hCDAB, 4'h7);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule